// File: doc/BRIEF.md
# Carry-Bypass Adder with Grouped Ripple Chains

This block adds two unsigned (or two's complement) operands of `WIDTH` bits together with a one-bit carry-in. It returns the `WIDTH`-bit sum and the carry out of the top bit. It has no clock and no storage. Its outputs follow its inputs through combinational logic only.

Internally, the operand bits are split into groups of `GROUP` bits, four by default. Each bit forms a propagate term (the XOR of its operand bits) and a generate term (the AND of its operand bits). Inside a group, the carry ripples from bit to bit. A group is fully propagating when every one of its bits propagates. In that case a 2:1 selector hands the group's incoming carry straight to the next group. Otherwise the selector passes on the carry that left the group's top bit. Because a fully propagating group hands its incoming carry on unchanged, the carry path through such a group is shortened.

The structure is written out instance by instance so that the per-bit cells, the ripple chain and the bypass selector can each be seen in the code. `WIDTH` must be a whole multiple of `GROUP`.

Top module: `cba_adder`

## Requirements
- R1: `sum_out` equals the low `WIDTH` bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit `WIDTH` of the `(WIDTH+1)`-bit result of `op_a + op_b + carry_in`.
- R3: When every bit of every group propagates (`op_b == ~op_a`), the following hold:
  - `carry_out` equals `carry_in`.
  - `sum_out` is all ones when `carry_in` is 0.
  - `sum_out` is all zeros when `carry_in` is 1.
- R4: When the top bit of a group generates (both operand bits 1), the carry entering the next group is 1 whatever the carry-in, and the result still matches R1 and R2.
- R5: With both operands zero, `sum_out` equals `carry_in` zero-extended and `carry_out` is 0.
- R6: The block is purely combinational. A change on any input shows on the outputs in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The embedded checks assume that every input carries a known 0 or 1; they skip evaluation while any operand bit is unknown. The checks also assume that they are evaluated only after the combinational network has settled for a given input set.

The bench meets both assumptions as follows:
- It drives every input with a defined value from time zero.
- It changes inputs only just after a falling clock edge.
- It reads outputs a quarter period later.

The stimulus mixes fixed vectors with whole-word propagate patterns and top-bit generate patterns, so both selector branches are exercised in each group.

// File: rtl/cba_pkg.sv
// Shared constants and helpers for the carry-bypass adder.
// Assumes: widths handed to the helpers are whole multiples of the group size.
package cba_pkg;

    localparam int unsigned CBA_WIDTH_DEFAULT = 16;
    localparam int unsigned CBA_GROUP_DEFAULT = 4;

    // Number of bypass groups for a given total width and group size.
    function automatic int unsigned cba_groups(input int unsigned width, input int unsigned grp);
        return width / grp;
    endfunction

endpackage

// File: rtl/cba_pg_cell.sv
// Per-bit propagate/generate cell.
// Computes the propagate term as the XOR of the two operand bits and the
// generate term as their AND. Assumes known inputs.
module cba_pg_cell (
    input  logic bit_a,
    input  logic bit_b,
    output logic prop,
    output logic gen
);

    // Form propagate and generate from the operand bits.
    always_comb begin
        prop = bit_a ^ bit_b;
        gen  = bit_a & bit_b;
    end

    // R1: a bit can never both propagate and generate
    always_comb begin
        if (!$isunknown({bit_a, bit_b})) begin
            // R1
            pg_exclusive_chk: assert (!(prop && gen))
                else $error("propagate and generate both high");
        end
    end

endmodule

// File: rtl/cba_carry_cell.sv
// Per-bit carry and sum cell.
// From propagate, generate and the incoming carry it produces the sum bit and
// the carry leaving the bit. Assumes propagate and generate come from a pg cell.
module cba_carry_cell (
    input  logic prop,
    input  logic gen,
    input  logic c_in,
    output logic sum_bit,
    output logic c_out
);

    // Sum bit and outgoing carry of one position.
    always_comb begin
        sum_bit = prop ^ c_in;
        c_out   = gen | (prop & c_in);
    end

endmodule

// File: rtl/cba_group.sv
// One bypass group of GW bits.
// The carry ripples through GW carry cells. The group propagate is the AND of
// all per-bit propagate terms. A 2:1 selector driven by it forwards either the
// group carry-in (all bits propagate) or the rippled carry.
// Assumes GW >= 1.
module cba_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] grp_a,
    input  logic [GW-1:0] grp_b,
    input  logic          grp_cin,
    output logic [GW-1:0] grp_sum,
    output logic          grp_cout
);

    logic [GW-1:0] p_vec;
    logic [GW-1:0] g_vec;
    logic [GW:0]   ripple;
    logic          grp_prop;

    assign ripple[0] = grp_cin;

    // Per-bit propagate/generate and ripple-carry cells.
    for (genvar i = 0; i < GW; i++) begin : g_bit
        cba_pg_cell u_pg (
            .bit_a (grp_a[i]),
            .bit_b (grp_b[i]),
            .prop  (p_vec[i]),
            .gen   (g_vec[i])
        );
        cba_carry_cell u_cc (
            .prop    (p_vec[i]),
            .gen     (g_vec[i]),
            .c_in    (ripple[i]),
            .sum_bit (grp_sum[i]),
            .c_out   (ripple[i+1])
        );
    end

    // Group propagate over all bits of the group.
    always_comb begin
        grp_prop = &p_vec;
    end

    // Bypass selector: skip the ripple chain when every bit propagates.
    always_comb begin
        grp_cout = grp_prop ? grp_cin : ripple[GW];
    end

    // Guards on the group result against a behavioural sum.
    always_comb begin
        if (!$isunknown({grp_a, grp_b, grp_cin})) begin
            // R1
            grp_arith_chk: assert ({grp_cout, grp_sum} ==
                                   ((GW+1)'(grp_a) + (GW+1)'(grp_b) + (GW+1)'(grp_cin)))
                else $error("group result differs from addition");
            // R3
            bypass_ripple_agree_chk: assert (!grp_prop || (ripple[GW] == grp_cin))
                else $error("ripple carry disagrees with bypass path");
            // R4
            top_generate_chk: assert (!(grp_a[GW-1] && grp_b[GW-1]) || grp_cout)
                else $error("top-bit generate lost");
        end
    end

endmodule

// File: rtl/cba_adder.sv
// Carry-bypass adder, top level.
// It chains WIDTH/GROUP bypass groups. Each group's selected carry feeds the
// next group, and the last one is the adder carry-out. The adder is purely
// combinational.
// Assumes WIDTH is a whole multiple of GROUP.
module cba_adder
    import cba_pkg::*;
#(
    parameter int unsigned WIDTH = CBA_WIDTH_DEFAULT,
    parameter int unsigned GROUP = CBA_GROUP_DEFAULT
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int unsigned NGRP = cba_groups(WIDTH, GROUP);

    logic [NGRP:0] grp_carry;

    assign grp_carry[0] = carry_in;

    // One bypass group per GROUP-bit slice, chained through grp_carry.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cba_group #(
            .GW (GROUP)
        ) u_grp (
            .grp_a    (op_a[g*GROUP +: GROUP]),
            .grp_b    (op_b[g*GROUP +: GROUP]),
            .grp_cin  (grp_carry[g]),
            .grp_sum  (sum_out[g*GROUP +: GROUP]),
            .grp_cout (grp_carry[g+1])
        );
    end

    // Final carry leaves the last group.
    always_comb begin
        carry_out = grp_carry[NGRP];
    end

    // End-to-end guards on the full-width result.
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            // R2
            full_sum_chk: assert ({carry_out, sum_out} ==
                                  ((WIDTH+1)'(op_a) + (WIDTH+1)'(op_b) + (WIDTH+1)'(carry_in)))
                else $error("adder result differs from addition");
            // R3
            all_prop_chk: assert ((op_b != ~op_a) || (carry_out == carry_in))
                else $error("all-propagate carry not passed through");
        end
    end

endmodule

// File: tb/cba_adder_test.sv
// Self-checking bench for cba_adder: vector table, then directed tests.
module cba_adder_test;

    localparam int unsigned W = 16;
    localparam int unsigned G = 4;
    localparam int NV = 12;

    // Layout: a[49:34] b[33:18] cin[17] sum[16:1] cout[0]
    localparam logic [49:0] VECS [NV] = '{
        {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},
        {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
        {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
        {16'h5555, 16'hAAAA, 1'b0, 16'hFFFF, 1'b0},
        {16'h5555, 16'hAAAA, 1'b1, 16'h0000, 1'b1},
        {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
        {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0},
        {16'h0F0F, 16'hF0F0, 1'b1, 16'h0000, 1'b1},
        {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},
        {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0},
        {16'h000F, 16'h0000, 1'b1, 16'h0010, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    cba_adder #(.WIDTH(W), .GROUP(G)) uut (
        .op_a      (a),
        .op_b      (b),
        .carry_in  (cin),
        .sum_out   (sum),
        .carry_out (cout)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after a falling edge, sample a quarter period later.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        @(negedge clk);
        a = va; b = vb; cin = vc;
        #5;
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        return {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    endfunction

    initial begin
        logic [W-1:0] ra;
        logic [W:0]   e;

        // Reset phase: zero operands give a zero result (R5).
        repeat (3) @(posedge clk);
        apply('0, '0, 1'b0);
        check("R5 reset-state", {cout, sum}, '0);
        rst_n = 1'b1;

        // Vector table (R1 sum, R2 carry).
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][49:34], VECS[i][33:18], VECS[i][17]);
            check("R1 table sum", {1'b0, sum}, {1'b0, VECS[i][16:1]});
            check("R2 table carry", {{W{1'b0}}, cout}, {{W{1'b0}}, VECS[i][0]});
        end

        // R5: carry-in only.
        apply('0, '0, 1'b1);
        check("R5 carry-in only", {cout, sum}, {1'b0, {(W-1){1'b0}}, 1'b1});

        // R3: every bit propagates.
        for (int k = 0; k < 40; k++) begin
            ra = W'($urandom);
            apply(ra, ~ra, k[0]);
            check("R3 all-propagate", {cout, sum}, {k[0], {W{~k[0]}}});
        end

        // R4: top bit of each group generates.
        for (int g = 0; g < W / G; g++) begin
            for (int c = 0; c < 2; c++) begin
                ra = W'($urandom);
                ra[g*G + G - 1] = 1'b1;
                apply(ra, W'(1) << (g*G + G - 1), c[0]);
                e = model(ra, W'(1) << (g*G + G - 1), c[0]);
                check("R4 group generate", {cout, sum}, e);
            end
        end

        // R1/R2: random operands against behavioural addition.
        for (int k = 0; k < 3000; k++) begin
            ra = W'($urandom);
            apply(ra, W'($urandom), 1'($urandom));
            e = model(a, b, cin);
            check("R1 random sum", {1'b0, sum}, {1'b0, e[W-1:0]});
            check("R2 random carry", {{W{1'b0}}, cout}, {{W{1'b0}}, e[W]});
        end

        // R6: outputs follow inputs with no clock edge in between.
        @(negedge clk);
        a = 16'h0001; b = 16'h0001; cin = 1'b0;
        #1;
        check("R6 comb first", {cout, sum}, 17'h00002);
        a = 16'hFFFF; b = 16'h0000; cin = 1'b1;
        #1;
        check("R6 comb second", {cout, sum}, 17'h10000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule